// File: doc/BRIEF.md
# Burst Tagger and Route Selector

This block sits at the source side of a push-only event-building network that runs with no trigger. It cuts continuous time into bursts. Each burst is an active window in which data is accepted, followed by a silent gap. A fixed number of bursts forms one super-burst. The block keeps a running position inside this time frame and chooses one destination compute node per burst. The choice follows a fixed-stride round robin over the node count, so that successive bursts spread evenly across the sink nodes.

Each fragment strobe returns a tag one cycle later. The tag carries the destination node, the burst position within the super-burst, the super-burst count, and two routing flags. The first flag picks the path order at the source level: over the backplane first, or over the trunk first. The second flag marks an odd destination node, which the receiving level must forward across its backplane. The tag also reports the payload length after 8b/10b line coding.

Top module: `burst_route_tagger`

## Requirements
- R1: `burst_active` is high for ACT = CLK_MHZ*2000/1000 cycles and then low for GAP = CLK_MHZ*400/1000 cycles, and this repeats (500 and 100 cycles at 250 MHz). The first cycle after reset is the first active cycle of burst 0.
- R2: The burst position runs 0..9 and wraps to 0, and the super-burst counter (8 bits, wrapping) increments on each wrap. `super_start` is high exactly in the first active cycle of a burst whose position is 0.
- R3: The destination of burst n+1 equals (destination of burst n + 79) mod 416, and burst 0 goes to node 0. The new value is in effect from the first cycle of the new burst.
- R4: All fragments strobed within one burst carry the same destination, position and super-burst count. A strobe in the silent gap is tagged with the burst whose active window has just ended.
- R5: `tag_backplane_first` is 1 for fragments of odd-numbered bursts (counting from burst 0) and 0 for even-numbered bursts.
- R6: `tag_dest_odd` equals bit 0 of the destination node number carried in the same tag.
- R7: `coded_len` equals ceil(10*frag_bytes/8), computed for the full 16-bit byte range.
- R8: `tag_valid` is high in the cycle after each cycle in which `frag_valid` is high, and low otherwise. The tag fields describe the state during the strobe cycle. Back-to-back strobes yield back-to-back tags.
- R9: While reset is held, `tag_valid` is 0, the tag fields and `coded_len` are 0, and `burst_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frag_valid | input | 1 | A fragment is presented in this cycle |
| frag_bytes | input | 16 | Raw fragment length in bytes |
| burst_active | output | 1 | High during the active window of a burst |
| super_start | output | 1 | First active cycle of the first burst of a super-burst |
| tag_valid | output | 1 | Tag fields are valid |
| tag_dest | output | 9 | Destination compute node |
| tag_sub | output | 4 | Burst position within the super-burst |
| tag_super | output | 8 | Super-burst counter |
| tag_backplane_first | output | 1 | Cross the backplane before the trunk |
| tag_dest_odd | output | 1 | Destination node number is odd |
| coded_len | output | 17 | Payload length after 8b/10b coding |

## Verification
The bench strobes fragments on the last active cycle, the first and last gap cycles and the first cycle of a new burst. A design that moved the burst count at the end of the active window, rather than after the gap, would tag gap fragments with the next destination. The run goes past the first modulo wrap at burst 6 (node 58) and past two super-burst wraps. A wrong stride or a missed subtraction therefore shows up as a bad destination, and a bad position reset shows up as a missing `super_start` at burst 10. Byte counts of 0, 1, 3 and 65535 expose a rounding-down or overflowing length, and four back-to-back strobes catch a tag stage that drops or merges fragments.

// File: rtl/burst_route_pkg.sv
package burst_route_pkg;

  typedef enum logic {
    ROUTE_TRUNK_FIRST     = 1'b0,
    ROUTE_BACKPLANE_FIRST = 1'b1
  } route_order_e;

  localparam int NS_PER_US = 1000;

endpackage

// File: rtl/burst_timer.sv
module burst_timer #(
  parameter int CLK_MHZ = 250,
  parameter int ACT_NS  = 2000,
  parameter int GAP_NS  = 400,
  parameter int SUB_N   = 10,
  parameter int SUB_W   = 4,
  parameter int SUP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             burst_active,
  output logic             burst_end,
  output logic             super_start,
  output logic [SUB_W-1:0] sub_idx,
  output logic [SUP_W-1:0] super_cnt,
  output logic             burst_odd
);
  import burst_route_pkg::*;

  localparam int ACT    = CLK_MHZ * ACT_NS / NS_PER_US;
  localparam int GAP    = CLK_MHZ * GAP_NS / NS_PER_US;
  localparam int PERIOD = ACT + GAP;
  localparam int PH_W   = $clog2(PERIOD);

  logic [PH_W-1:0] phase;
  logic            sub_wrap;

  assign burst_active = (phase < PH_W'(ACT));
  assign burst_end    = (phase == PH_W'(PERIOD - 1));
  assign sub_wrap     = (sub_idx == SUB_W'(SUB_N - 1));
  assign super_start  = (phase == '0) && (sub_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      sub_idx   <= '0;
      super_cnt <= '0;
      burst_odd <= 1'b0;
    end else if (burst_end) begin
      phase     <= '0;
      burst_odd <= ~burst_odd;
      if (sub_wrap) begin
        sub_idx   <= '0;
        super_cnt <= super_cnt + SUP_W'(1);
      end else begin
        sub_idx   <= sub_idx + SUB_W'(1);
      end
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  assert_gap_after_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_W'(ACT - 1)) |=> !burst_active);
  assert_burst_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (burst_active && phase == '0));
  assert_super_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && sub_wrap) |=> (sub_idx == '0 && super_cnt == $past(super_cnt) + SUP_W'(1)));
  assert_sub_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_idx < SUB_W'(SUB_N));
  assert_parity_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (burst_odd != $past(burst_odd)));

endmodule

// File: rtl/dest_stepper.sv
module dest_stepper #(
  parameter int NODES  = 416,
  parameter int STRIDE = 79,
  parameter int DEST_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_end,
  output logic [DEST_W-1:0] dest
);

  function automatic logic [DEST_W-1:0] step_dest(input logic [DEST_W-1:0] cur);
    logic [DEST_W:0] sum;
    sum = {1'b0, cur} + (DEST_W+1)'(STRIDE);
    if (sum >= (DEST_W+1)'(NODES)) sum = sum - (DEST_W+1)'(NODES);
    return DEST_W'(sum);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dest <= '0;
    else if (burst_end) dest <= step_dest(dest);
  end

  assert_dest_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dest < DEST_W'(NODES));
  assert_dest_held_in_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_end |=> $stable(dest));

endmodule

// File: rtl/frag_tagger.sv
module frag_tagger #(
  parameter int DEST_W = 9,
  parameter int SUB_W  = 4,
  parameter int SUP_W  = 8,
  parameter int BYTE_W = 16,
  parameter int COD_W  = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frag_valid,
  input  logic [BYTE_W-1:0] frag_bytes,
  input  logic [DEST_W-1:0] dest,
  input  logic [SUB_W-1:0]  sub_idx,
  input  logic [SUP_W-1:0]  super_cnt,
  input  logic              burst_odd,
  output logic              tag_valid,
  output logic [DEST_W-1:0] tag_dest,
  output logic [SUB_W-1:0]  tag_sub,
  output logic [SUP_W-1:0]  tag_super,
  output logic              tag_backplane_first,
  output logic              tag_dest_odd,
  output logic [COD_W-1:0]  coded_len
);
  import burst_route_pkg::*;

  function automatic logic [COD_W-1:0] line_coded(input logic [BYTE_W-1:0] raw);
    logic [BYTE_W+2:0] wide;
    wide = (BYTE_W+3)'(raw) * (BYTE_W+3)'(5) + (BYTE_W+3)'(3);
    return COD_W'(wide >> 2);
  endfunction

  route_order_e order_now;
  assign order_now = burst_odd ? ROUTE_BACKPLANE_FIRST : ROUTE_TRUNK_FIRST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_valid           <= 1'b0;
      tag_dest            <= '0;
      tag_sub             <= '0;
      tag_super           <= '0;
      tag_backplane_first <= 1'b0;
      tag_dest_odd        <= 1'b0;
      coded_len           <= '0;
    end else begin
      tag_valid <= frag_valid;
      if (frag_valid) begin
        tag_dest            <= dest;
        tag_sub             <= sub_idx;
        tag_super           <= super_cnt;
        tag_backplane_first <= (order_now == ROUTE_BACKPLANE_FIRST);
        tag_dest_odd        <= dest[0];
        coded_len           <= line_coded(frag_bytes);
      end
    end
  end

  assert_tag_follows_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |=> tag_valid);
  assert_no_tag_without_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frag_valid |=> !tag_valid);
  assert_coded_not_shorter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |=> (coded_len >= COD_W'($past(frag_bytes))));
  assert_route_from_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |=> (tag_backplane_first == $past(burst_odd)));

endmodule

// File: rtl/burst_route_tagger.sv
module burst_route_tagger #(
  parameter int CLK_MHZ = 250,
  parameter int ACT_NS  = 2000,
  parameter int GAP_NS  = 400,
  parameter int SUB_N   = 10,
  parameter int NODES   = 416,
  parameter int STRIDE  = 79,
  parameter int BYTE_W  = 16,
  parameter int SUP_W   = 8,
  localparam int DEST_W = $clog2(NODES),
  localparam int SUB_W  = $clog2(SUB_N),
  localparam int COD_W  = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frag_valid,
  input  logic [BYTE_W-1:0] frag_bytes,
  output logic              burst_active,
  output logic              super_start,
  output logic              tag_valid,
  output logic [DEST_W-1:0] tag_dest,
  output logic [SUB_W-1:0]  tag_sub,
  output logic [SUP_W-1:0]  tag_super,
  output logic              tag_backplane_first,
  output logic              tag_dest_odd,
  output logic [COD_W-1:0]  coded_len
);

  logic              burst_end;
  logic [SUB_W-1:0]  sub_idx;
  logic [SUP_W-1:0]  super_cnt;
  logic              burst_odd;
  logic [DEST_W-1:0] dest;

  burst_timer #(
    .CLK_MHZ(CLK_MHZ), .ACT_NS(ACT_NS), .GAP_NS(GAP_NS),
    .SUB_N(SUB_N), .SUB_W(SUB_W), .SUP_W(SUP_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .burst_active(burst_active), .burst_end(burst_end), .super_start(super_start),
    .sub_idx(sub_idx), .super_cnt(super_cnt), .burst_odd(burst_odd)
  );

  dest_stepper #(
    .NODES(NODES), .STRIDE(STRIDE), .DEST_W(DEST_W)
  ) u_dest (
    .clk(clk), .rst_n(rst_n), .burst_end(burst_end), .dest(dest)
  );

  frag_tagger #(
    .DEST_W(DEST_W), .SUB_W(SUB_W), .SUP_W(SUP_W), .BYTE_W(BYTE_W), .COD_W(COD_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_n),
    .frag_valid(frag_valid), .frag_bytes(frag_bytes),
    .dest(dest), .sub_idx(sub_idx), .super_cnt(super_cnt), .burst_odd(burst_odd),
    .tag_valid(tag_valid), .tag_dest(tag_dest), .tag_sub(tag_sub), .tag_super(tag_super),
    .tag_backplane_first(tag_backplane_first), .tag_dest_odd(tag_dest_odd),
    .coded_len(coded_len)
  );

  assert_dest_steps_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && dest >= DEST_W'(NODES - STRIDE)) |=> (dest < $past(dest)));
  assert_tag_odd_matches_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |=> (tag_dest_odd == $past(dest[0])));

endmodule

// File: tb/burst_route_tagger_bench.sv
module burst_route_tagger_bench;

  localparam int ACT    = 500;
  localparam int PERIOD = 600;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frag_valid;
  logic [15:0] frag_bytes;
  logic        burst_active, super_start, tag_valid;
  logic [8:0]  tag_dest;
  logic [3:0]  tag_sub;
  logic [7:0]  tag_super;
  logic        tag_backplane_first, tag_dest_odd;
  logic [16:0] coded_len;

  always #2 clk = ~clk;

  burst_route_tagger u_burst_route_tagger (
    .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_bytes(frag_bytes),
    .burst_active(burst_active), .super_start(super_start), .tag_valid(tag_valid),
    .tag_dest(tag_dest), .tag_sub(tag_sub), .tag_super(tag_super),
    .tag_backplane_first(tag_backplane_first), .tag_dest_odd(tag_dest_odd),
    .coded_len(coded_len)
  );

  typedef struct {
    int dest; int sub; int sup; int bp; int odd; int len;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   t;
  bit   finished = 0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) t <= 0;
    else        t <= t + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, expv, t);
    end
  endtask

  function automatic exp_t model(input int now, input int bytes);
    exp_t e;
    int burst;
    burst = now / PERIOD;
    e.dest = (79 * burst) % 416;
    e.sub  = burst % 10;
    e.sup  = (burst / 10) % 256;
    e.bp   = burst % 2;
    e.odd  = e.dest % 2;
    e.len  = (bytes * 10 + 7) / 8;
    return e;
  endfunction

  task automatic send(input int bytes);
    exp_q.push_back(model(t, bytes));
    frag_valid = 1'b1;
    frag_bytes = 16'(bytes);
    @(negedge clk);
    frag_valid = 1'b0;
  endtask

  task automatic goto(input int when);
    while (t != when) @(negedge clk);
  endtask

  function automatic int pick(input int b, input int k);
    if (b == 3) return k;
    if (b == 4) return (k == 0) ? 65535 : (k == 1) ? 4 : (k == 2) ? 5 : 7;
    return (b * 37 + k * 1013) % 65536;
  endfunction

  // Monitor: pops the scoreboard whenever a tag comes out
  always @(negedge clk) begin
    if (rst_n && tag_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected tag", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(tag_dest) == e.dest, "R3/R4 dest", int'(tag_dest), e.dest);
        chk(int'(tag_sub) == e.sub, "R2/R4 burst position", int'(tag_sub), e.sub);
        chk(int'(tag_super) == e.sup, "R2 super count", int'(tag_super), e.sup);
        chk(int'(tag_backplane_first) == e.bp, "R5 route order", int'(tag_backplane_first), e.bp);
        chk(int'(tag_dest_odd) == e.odd, "R6 dest odd", int'(tag_dest_odd), e.odd);
        chk(int'(coded_len) == e.len, "R7 coded length", int'(coded_len), e.len);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 15000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    frag_valid = 1'b0;
    frag_bytes = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(burst_active == 1'b1, "R9 active in reset", int'(burst_active), 1);
    chk(tag_valid == 1'b0, "R9 no tag in reset", int'(tag_valid), 0);
    chk(tag_dest == '0, "R9 dest in reset", int'(tag_dest), 0);
    chk(coded_len == '0, "R9 length in reset", int'(coded_len), 0);
    rst_n = 1'b1;

    for (int b = 0; b < 25; b++) begin
      goto(b * PERIOD);
      chk(burst_active == 1'b1, "R1 first active cycle", int'(burst_active), 1);
      chk(int'(super_start) == ((b % 10 == 0) ? 1 : 0), "R2 super_start",
          int'(super_start), (b % 10 == 0) ? 1 : 0);
      send(pick(b, 0));
      if (b == 2) begin
        goto(b * PERIOD + 10);
        for (int k = 0; k < 4; k++) send(1000 + k);   // R8 back-to-back
      end
      goto(b * PERIOD + 250);
      send(pick(b, 1));
      goto(b * PERIOD + ACT - 1);
      chk(burst_active == 1'b1, "R1 last active cycle", int'(burst_active), 1);
      send(pick(b, 2));
      chk(burst_active == 1'b0, "R1 first gap cycle", int'(burst_active), 0);
      send(pick(b, 3));                                // R4: gap strobe
      goto(b * PERIOD + PERIOD - 1);
      chk(burst_active == 1'b0, "R1 last gap cycle", int'(burst_active), 0);
      send(pick(b, 2) ^ 16'h00ff);
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 tags outstanding", exp_q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule